// File: doc/BRIEF.md
# Branch Target Buffer with Static Direction Fallback

This block gives the fetch unit a next fetch address for a branch in the same cycle that the branch address is presented. It holds a small, fully associative set of entries. Each entry is keyed by a branch address and stores two things: the target that branch last resolved to, and a 2-bit direction counter. When a lookup hits, the counter picks the direction. A taken prediction sends fetch to the stored target, and a not-taken prediction sends fetch to the sequential successor.

When a lookup misses, the block uses a fixed rule based on the target that decode supplies. A target below the branch address is predicted taken, because backward branches usually close loops. A target at or above the branch address is predicted not taken, and fetch continues at the next sequential instruction.

A single update port carries each resolved branch back to the block, together with the prediction that was made for it. The block raises a mispredict flag in that same cycle so that the pipeline can flush. It also trains the matching entry. A branch that has no entry and resolved taken gets a new entry, which takes a free slot or evicts the least recently updated entry.

Each entry's direction counter is a four-state machine:

| State | Value | Predicts | On taken | On not taken |
|---|---|---|---|---|
| `CTR_STRONG_NT` | 0 | not taken | to `CTR_WEAK_NT` | stays |
| `CTR_WEAK_NT` | 1 | not taken | to `CTR_WEAK_T` | to `CTR_STRONG_NT` |
| `CTR_WEAK_T` | 2 | taken | to `CTR_STRONG_T` | to `CTR_WEAK_NT` |
| `CTR_STRONG_T` | 3 | taken | stays | to `CTR_WEAK_T` |

A newly allocated entry starts in `CTR_WEAK_T` if its branch is backward and in `CTR_WEAK_NT` if it is forward.

Top module: `btb_predictor`

## Requirements
- R1: After reset, no entry is valid, so every lookup reports `hit_o` = 0.
- R2: On a lookup hit, `pred_target_o` is the target most recently written for that branch address if the counter predicts taken; otherwise it is `fetch_pc_i + INSN_BYTES`.
- R3: On a lookup miss, the block predicts taken with `pred_target_o = dec_target_i` when `dec_target_i < fetch_pc_i` (an unsigned compare). Otherwise it predicts not taken with `pred_target_o = fetch_pc_i + INSN_BYTES` (default 4).
- R4: The direction counter is 2 bits and saturates. It predicts taken at values 2 and 3. A resolved taken branch moves it up by one and stops at 3; a resolved not-taken branch moves it down by one and stops at 0.
- R5: An update that misses allocates an entry only when the branch resolved taken. The new entry's counter starts at 2 if `upd_target_i < upd_pc_i` and at 1 otherwise. A not-taken miss leaves every entry unchanged.
- R6: An update that hits always overwrites the stored target with `upd_target_i` and steps the counter, whichever direction the branch resolved.
- R7: There are `ENTRIES` (default 8) entries. Allocation picks the lowest-indexed invalid entry if one exists, and otherwise picks the entry whose last allocation or update is the oldest.
- R8: `mispredict_o` is 1 exactly when `upd_valid_i` is 1 and either the resolved direction differs from `upd_pred_taken_i`, or the branch resolved taken to a target different from `upd_pred_target_i`.
- R9: A lookup sees the table as it stood before any update presented in the same cycle. That update becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc_i | input | ADDR_W | Branch address looked up |
| dec_target_i | input | ADDR_W | Target from decode, used only on a miss |
| hit_o | output | 1 | Lookup matched a valid entry |
| pred_taken_o | output | 1 | Predicted direction |
| pred_target_o | output | ADDR_W | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | ADDR_W | Resolved branch address |
| upd_taken_i | input | 1 | Resolved direction |
| upd_target_i | input | ADDR_W | Resolved target |
| upd_pred_taken_i | input | 1 | Direction that was predicted |
| upd_pred_target_i | input | ADDR_W | Target that was predicted |
| mispredict_o | output | 1 | Prediction was wrong, pipeline must flush |

## Verification
Directed sequences cover four separate cases:
- a lookup with no entry, once with a backward target and once with a forward target, which exercises the static rule;
- a single branch driven through every counter transition, which shows that the counter saturates and that one wrong guess does not flip a strongly biased entry;
- a fill of all entries followed by one refresh and one new allocation, which shows whether the victim is the least recently updated entry or simply a fixed slot;
- an update and a lookup of the same address in the same cycle, which separates old-state reads from forwarding.

Seeded random traffic then draws branch addresses from a pool larger than the table, mixes backward and forward targets, and supplies predicted values that sometimes match the outcome and sometimes do not. This drives hits, misses, evictions and both mispredict causes, and every output is compared with a reference model held in the bench.

// File: rtl/btb_pkg.sv
package btb_pkg;
    // Two-bit direction counter states, ordered so that bit 1 is the prediction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_state_t;
endpackage

// File: rtl/btb_lru.sv
module btb_lru #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               touch_i,
    input  logic [IDX_W-1:0]   touch_idx_i,
    output logic [IDX_W-1:0]   victim_o
);
    // Each entry holds a distinct age; age 0 is the most recently touched.
    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] oldest_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx_i)          age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_oldest
        assign oldest_vec[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
    end

    // A free slot wins over the oldest entry; among free slots, the lowest index wins.
    always_comb begin
        victim_o = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (oldest_vec[i]) victim_o = IDX_W'(i);
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (!valid_i[i]) victim_o = IDX_W'(i);
    end

    assert_single_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1);
    assert_touch_youngest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        touch_i |=> age_q[$past(touch_idx_i)] == '0);
endmodule

// File: rtl/btb_entry.sv
module btb_entry
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              alloc_i,
    input  logic              refresh_i,
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic              valid_o,
    output logic              lk_hit_o,
    output logic              upd_hit_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              pred_taken_o
);
    logic              valid_q;
    logic [ADDR_W-1:0] tag_q;
    logic [ADDR_W-1:0] target_q;
    ctr_state_t        ctr_q, ctr_d;

    // Next-state logic of the direction counter.
    always_comb begin
        ctr_d = ctr_q;
        if (alloc_i) begin
            ctr_d = (target_i < upd_pc_i) ? CTR_WEAK_T : CTR_WEAK_NT;
        end else if (refresh_i) begin
            unique case (ctr_q)
                CTR_STRONG_NT: ctr_d = taken_i ? CTR_WEAK_NT  : CTR_STRONG_NT;
                CTR_WEAK_NT:   ctr_d = taken_i ? CTR_WEAK_T   : CTR_STRONG_NT;
                CTR_WEAK_T:    ctr_d = taken_i ? CTR_STRONG_T : CTR_WEAK_NT;
                CTR_STRONG_T:  ctr_d = taken_i ? CTR_STRONG_T : CTR_WEAK_T;
            endcase
        end
    end

    // State register of the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= CTR_WEAK_NT;
        else        ctr_q <= ctr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            tag_q    <= '0;
            target_q <= '0;
        end else if (alloc_i) begin
            valid_q  <= 1'b1;
            tag_q    <= upd_pc_i;
            target_q <= target_i;
        end else if (refresh_i) begin
            target_q <= target_i;
        end
    end

    // Outputs.
    always_comb begin
        valid_o      = valid_q;
        lk_hit_o     = valid_q && (tag_q == lk_pc_i);
        upd_hit_o    = valid_q && (tag_q == upd_pc_i);
        target_o     = target_q;
        pred_taken_o = (ctr_q == CTR_WEAK_T) || (ctr_q == CTR_STRONG_T);
    end

    assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && taken_i && ctr_q == CTR_STRONG_T) |=> ctr_q == CTR_STRONG_T);
    assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_i && !taken_i && ctr_q == CTR_STRONG_NT) |=> ctr_q == CTR_STRONG_NT);
    assert_alloc_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (pred_taken_o == $past(target_i < upd_pc_i)) && upd_hit_o == (upd_pc_i == $past(upd_pc_i)));
    assert_refresh_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> target_o == $past(target_i));
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    input  logic [ADDR_W-1:0] dec_target_i,
    output logic              hit_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] pred_target_o,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    input  logic              upd_pred_taken_i,
    input  logic [ADDR_W-1:0] upd_pred_target_i,
    output logic              mispredict_o
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] valid_vec, lk_hit_vec, upd_hit_vec, ent_taken_vec;
    logic [ENTRIES-1:0] alloc_vec, refresh_vec;
    logic [ADDR_W-1:0]  ent_target [ENTRIES];
    logic [IDX_W-1:0]   victim_idx, upd_idx;
    logic               upd_any_hit, alloc_we, refresh_we;
    logic               lk_taken;
    logic [ADDR_W-1:0]  lk_target;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign alloc_vec[g]   = alloc_we && (victim_idx == IDX_W'(g));
        assign refresh_vec[g] = refresh_we && upd_hit_vec[g];
        btb_entry #(.ADDR_W(ADDR_W)) i_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .lk_pc_i      (fetch_pc_i),
            .upd_pc_i     (upd_pc_i),
            .alloc_i      (alloc_vec[g]),
            .refresh_i    (refresh_vec[g]),
            .taken_i      (upd_taken_i),
            .target_i     (upd_target_i),
            .valid_o      (valid_vec[g]),
            .lk_hit_o     (lk_hit_vec[g]),
            .upd_hit_o    (upd_hit_vec[g]),
            .target_o     (ent_target[g]),
            .pred_taken_o (ent_taken_vec[g])
        );
    end

    btb_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (valid_vec),
        .touch_i     (alloc_we || refresh_we),
        .touch_idx_i (upd_any_hit ? upd_idx : victim_idx),
        .victim_o    (victim_idx)
    );

    // Update side: find the matching entry, then choose refresh or allocate.
    always_comb begin
        upd_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (upd_hit_vec[i]) upd_idx = IDX_W'(i);
        upd_any_hit = |upd_hit_vec;
        refresh_we  = upd_valid_i && upd_any_hit;
        alloc_we    = upd_valid_i && !upd_any_hit && upd_taken_i;
    end

    // Lookup side: one-hot select of the matching entry.
    always_comb begin
        lk_taken  = 1'b0;
        lk_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_hit_vec[i]) begin
                lk_taken  = ent_taken_vec[i];
                lk_target = ent_target[i];
            end
        end
    end

    always_comb begin
        hit_o = |lk_hit_vec;
        if (hit_o) pred_taken_o = lk_taken;
        else       pred_taken_o = dec_target_i < fetch_pc_i;
        if (!pred_taken_o)  pred_target_o = fetch_pc_i + ADDR_W'(INSN_BYTES);
        else if (hit_o)     pred_target_o = lk_target;
        else                pred_target_o = dec_target_i;
        mispredict_o = upd_valid_i &&
                       ((upd_taken_i != upd_pred_taken_i) ||
                        (upd_taken_i && (upd_target_i != upd_pred_target_i)));
    end

    assert_unique_keys_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_hit_vec) <= 1 && $countones(upd_hit_vec) <= 1);
    assert_nt_miss_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && !upd_taken_i && !upd_any_hit) |=> $stable(valid_vec));
    assert_flag_needs_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |-> !mispredict_o);
    assert_reset_empty_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> valid_vec == '0);
endmodule

// File: tb/test_btb_predictor.sv
`timescale 1ns/1ps
module test_btb_predictor;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0, dec_target = '0;
    logic        hit, pred_taken, mispredict;
    logic [31:0] pred_target;
    logic        upd_valid = 1'b0, upd_taken = 1'b0, upd_pred_taken = 1'b0;
    logic [31:0] upd_pc = '0, upd_target = '0, upd_pred_target = '0;

    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    btb_predictor i_btb_predictor (
        .clk(clk), .rst_n(rst_n),
        .fetch_pc_i(fetch_pc), .dec_target_i(dec_target),
        .hit_o(hit), .pred_taken_o(pred_taken), .pred_target_o(pred_target),
        .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
        .upd_target_i(upd_target), .upd_pred_taken_i(upd_pred_taken),
        .upd_pred_target_i(upd_pred_target), .mispredict_o(mispredict)
    );

    // Reference model of the table.
    logic        m_valid [N];
    logic [31:0] m_tag   [N];
    logic [31:0] m_tgt   [N];
    int          m_ctr   [N];
    int          m_stamp [N];
    int          m_now = 0;

    function automatic int m_find(logic [31:0] pc);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == pc) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        int v = 0;
        for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
        for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[v]) v = i;
        return v;
    endfunction

    task automatic m_update(logic [31:0] pc, logic tk, logic [31:0] tgt);
        int i = m_find(pc);
        m_now++;
        if (i >= 0) begin
            m_tgt[i] = tgt;
            m_ctr[i] = tk ? ((m_ctr[i] == 3) ? 3 : m_ctr[i] + 1)
                          : ((m_ctr[i] == 0) ? 0 : m_ctr[i] - 1);
            m_stamp[i] = m_now;
        end else if (tk) begin
            i = m_victim();
            m_valid[i] = 1'b1; m_tag[i] = pc; m_tgt[i] = tgt;
            m_ctr[i] = (tgt < pc) ? 2 : 1;
            m_stamp[i] = m_now;
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_ctr[i] = 1; m_stamp[i] = 0;
        end
    endtask

    // One cycle: drive, check lookup and flag against the model, then train the model.
    task automatic step(logic [31:0] fpc, logic [31:0] dtgt, logic uv, logic [31:0] upc,
                        logic utk, logic [31:0] utgt, logic uptk, logic [31:0] uptgt);
        int  i;
        logic e_tk, e_mp;
        logic [31:0] e_tgt;
        @(negedge clk);
        fetch_pc = fpc; dec_target = dtgt;
        upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_target = utgt;
        upd_pred_taken = uptk; upd_pred_target = uptgt;
        #1;
        i = m_find(fpc);
        if (i >= 0) begin
            e_tk = (m_ctr[i] >= 2);
            e_tgt = e_tk ? m_tgt[i] : fpc + 32'd4;
            chk("R2", "hit", {31'd0, hit}, 32'd1);
            chk("R4", "taken", {31'd0, pred_taken}, {31'd0, e_tk});
            chk("R2", "target", pred_target, e_tgt);
        end else begin
            e_tk = (dtgt < fpc);
            e_tgt = e_tk ? dtgt : fpc + 32'd4;
            chk("R3", "hit", {31'd0, hit}, 32'd0);
            chk("R3", "taken", {31'd0, pred_taken}, {31'd0, e_tk});
            chk("R3", "target", pred_target, e_tgt);
        end
        e_mp = uv && ((utk != uptk) || (utk && utgt != uptgt));
        chk("R8", "mispredict", {31'd0, mispredict}, {31'd0, e_mp});
        @(posedge clk);
        if (uv) m_update(upc, utk, utgt);
    endtask

    task automatic upd(logic [31:0] pc, logic tk, logic [31:0] tgt);
        step(pc + 32'h10000, pc + 32'h10008, 1'b1, pc, tk, tgt, tk, tgt);
    endtask

    task automatic probe(logic [31:0] pc, logic e_hit, logic e_tk, logic [31:0] e_tgt, string tag);
        @(negedge clk);
        fetch_pc = pc; dec_target = pc + 32'd8; upd_valid = 1'b0;
        #1;
        chk(tag, "probe hit", {31'd0, hit}, {31'd0, e_hit});
        chk(tag, "probe taken", {31'd0, pred_taken}, {31'd0, e_tk});
        chk(tag, "probe target", pred_target, e_tgt);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a, b, c;
        int unsigned seed;
        a = 32'h8000; b = 32'h9000; c = 32'hA000;
        seed = $urandom(32'd20111130);
        do_reset();
        probe(a, 1'b0, 1'b0, a + 4, "R1");
        // R3: miss falls back to the static rule
        step(a, a - 16, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        step(a, a + 64, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        step(a, a, 1'b0, '0, 1'b0, '0, 1'b0, '0);
        // R5: not-taken miss does not allocate; taken miss does
        upd(a, 1'b0, a + 64);
        probe(a, 1'b0, 1'b0, a + 4, "R5");
        upd(a, 1'b1, a + 64);
        probe(a, 1'b1, 1'b0, a + 4, "R5");
        upd(b, 1'b1, b - 32);
        probe(b, 1'b1, 1'b1, b - 32, "R5");
        // R4: counter walk and saturation
        upd(a, 1'b1, a + 64);
        upd(a, 1'b1, a + 64);
        upd(a, 1'b1, a + 64);
        probe(a, 1'b1, 1'b1, a + 64, "R4");
        upd(a, 1'b0, a + 64);
        probe(a, 1'b1, 1'b1, a + 64, "R4");
        upd(a, 1'b0, a + 64);
        probe(a, 1'b1, 1'b0, a + 4, "R4");
        upd(a, 1'b0, a + 64);
        upd(a, 1'b0, a + 64);
        upd(a, 1'b1, a + 64);
        probe(a, 1'b1, 1'b0, a + 4, "R4");
        // R6: not-taken update still rewrites the target
        upd(a, 1'b0, a + 128);
        upd(a, 1'b1, a + 128);
        upd(a, 1'b1, a + 128);
        probe(a, 1'b1, 1'b1, a + 128, "R6");
        // R8: both mispredict causes
        step(a, a, 1'b1, b, 1'b1, b - 32, 1'b1, b - 28);
        step(a, a, 1'b1, b, 1'b0, b - 32, 1'b1, b - 32);
        step(a, a, 1'b1, b, 1'b0, b - 32, 1'b0, b - 8);
        // R9: same-cycle update is not seen by the lookup
        @(negedge clk);
        fetch_pc = c; dec_target = c + 8;
        upd_valid = 1'b1; upd_pc = c; upd_taken = 1'b1; upd_target = c - 4;
        upd_pred_taken = 1'b1; upd_pred_target = c - 4;
        #1;
        chk("R9", "same-cycle hit", {31'd0, hit}, 32'd0);
        @(posedge clk);
        m_update(c, 1'b1, c - 4);
        probe(c, 1'b1, 1'b1, c - 4, "R9");
        // R7: fill, refresh the first, then evict the least recently updated
        do_reset();
        for (int k = 0; k < 8; k++) upd(32'h2000 + k * 32'h100, 1'b1, 32'h2040 + k * 32'h100);
        upd(32'h2000, 1'b1, 32'h2040);
        upd(32'h2800, 1'b1, 32'h2840);
        probe(32'h2100, 1'b0, 1'b0, 32'h2104, "R7");
        probe(32'h2000, 1'b1, 1'b1, 32'h2040, "R7");
        probe(32'h2800, 1'b1, 1'b0, 32'h2804, "R7");
        probe(32'h2200, 1'b1, 1'b0, 32'h2204, "R7");
        // Seeded random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] fpc, upc, utgt, dtgt;
            logic utk, uptk, uv;
            fpc = 32'h4000 + ($urandom % 12) * 32'h40;
            upc = 32'h4000 + ($urandom % 12) * 32'h40;
            case ($urandom % 4)
                0: utgt = upc - 32'h100;
                1: utgt = upc - 32'h10;
                2: utgt = upc + 32'h20;
                default: utgt = upc + 32'h200;
            endcase
            dtgt = ($urandom % 2) ? fpc - 32'h30 : fpc + 32'h30;
            uv   = ($urandom % 4) != 0;
            utk  = ($urandom % 3) != 0;
            uptk = ($urandom % 4) != 0 ? utk : !utk;
            step(fpc, dtgt, uv, upc, utk, utgt, uptk, ($urandom % 3) != 0 ? utgt : utgt + 4);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule